// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM's contents alive and brings the device up after reset. Reset starts a fixed power-up wait. The block then runs a burst of wake-up cycles. After that it issues refresh cycles evenly, one per refresh interval, for as long as it runs. Every cycle is a column-strobe-before-row-strobe refresh. The device chooses the row from its own internal counter, so the block produces no row address and leaves the data bus undriven.

The block shares the DRAM pins with an access controller through a request/grant handshake. It raises `bus_req` before it needs the bus and waits for `bus_gnt`. It then drives the row strobe, both column strobes, write enable and output enable directly. It drops the request only after the row precharge time has passed. Refresh demands that arrive while the bus is held elsewhere are queued in a bounded backlog. If the backlog would exceed its limit, the block pulses `deadline_miss`, clears `ready` and runs the wake-up burst again. `ready` stays low until a wake-up burst has completed.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, all strobes are high (inactive), `bus_req`, `ready` and `deadline_miss` are low, and `bus_req` stays low for at least PAUSE_CYC clock cycles.
- R2: In every cycle, both column strobes go low exactly CAS_LEAD cycles before the row strobe falls, and they stay low while the row strobe is low.
- R3: The row strobe stays low for exactly RAS_LOW cycles. After it rises, all strobes stay high and `bus_req` stays asserted for exactly RAS_PRE cycles.
- R4: Write enable and output enable are held high at all times, so the data bus is never driven and no data is transferred.
- R5: The column strobes fall only after `bus_gnt` has been seen high while `bus_req` is asserted. `bus_req` falls only when all strobes are high.
- R6: After the pause, WAKE_CNT refresh cycles are issued. `ready` rises in the cycle in which the last one's precharge ends, and not earlier.
- R7: With immediate grants and `ready` high, the block issues one refresh per REF_PERIOD cycles.
- R8: Grant delays that leave at most MAX_BACKLOG refreshes pending cause no deadline miss, and `ready` stays high.
- R9: When a refresh comes due while MAX_BACKLOG refreshes are already pending, `deadline_miss` pulses for one cycle and `ready` goes low in the next cycle. Exactly WAKE_CNT cycles are then issued before `ready` rises again.
- R10: Under random bounded grant latency, `ready` never drops and no deadline miss occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Grant of the DRAM pins from the arbiter |
| bus_req | output | 1 | Request for the DRAM pins, held through precharge |
| row_stb_n | output | 1 | Row strobe, active low |
| col_stb_lo_n | output | 1 | Lower-byte column strobe, active low |
| col_stb_hi_n | output | 1 | Upper-byte column strobe, active low |
| wr_n | output | 1 | Write enable, active low, held high |
| out_en_n | output | 1 | Output enable, active low, held high |
| ready | output | 1 | Device initialized and refresh up to date |
| deadline_miss | output | 1 | One-cycle pulse when the refresh backlog overflows |

## Verification
The assertions assume the arbiter behaves: it raises `bus_gnt` only while `bus_req` is high, and it keeps the grant until the request drops. They also assume every phase parameter is at least one and REF_PERIOD is at least two. The bench's arbiter grants only on a live request and releases the grant as soon as the request falls. Its random grant delays stay below the point where the backlog would overflow, except in one directed window where the grant is withheld on purpose to force a deadline miss.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE = 3'd0,
        CYC_REQ  = 3'd1,
        CYC_CAS  = 3'd2,
        CYC_RAS  = 3'd3,
        CYC_PRE  = 3'd4
    } cyc_state_e;

endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
    parameter int REF_PERIOD  = 1560,
    parameter int MAX_BACKLOG = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic served,
    output logic need,
    output logic miss
);
    localparam int TMR_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
    localparam int BL_W  = $clog2(MAX_BACKLOG + 2);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_PERIOD - 1);
    localparam logic [BL_W-1:0]  BL_FULL  = BL_W'(MAX_BACKLOG);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [BL_W-1:0]  backlog;
        logic             miss;
    } ivl_t;

    ivl_t s_q, s_d;
    logic tick;

    always_comb begin
        s_d      = s_q;
        s_d.miss = 1'b0;
        tick     = run && (s_q.tmr == TMR_LAST);
        if (!run) begin
            s_d.tmr     = '0;
            s_d.backlog = '0;
        end else begin
            s_d.tmr = tick ? '0 : s_q.tmr + 1'b1;
            if (tick && !served) begin
                if (s_q.backlog == BL_FULL) begin
                    s_d.miss    = 1'b1;
                    s_d.backlog = '0;
                end else begin
                    s_d.backlog = s_q.backlog + 1'b1;
                end
            end else if (!tick && served && (s_q.backlog != '0)) begin
                s_d.backlog = s_q.backlog - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign need = (s_q.backlog != '0);
    assign miss = s_q.miss;

endmodule

// File: rtl/drs_wake.sv
module drs_wake #(
    parameter int PAUSE_CYC = 20000,
    parameter int WAKE_CNT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic served,
    input  logic restart,
    output logic pause_done,
    output logic wake_need,
    output logic ready
);
    localparam int PS_W = $clog2(PAUSE_CYC + 1);
    localparam int WK_W = $clog2(WAKE_CNT + 1);
    localparam logic [PS_W-1:0] PAUSE_LAST = PS_W'(PAUSE_CYC - 1);
    localparam logic [WK_W-1:0] WAKE_INIT  = WK_W'(WAKE_CNT);

    typedef struct packed {
        logic [PS_W-1:0] pause_cnt;
        logic            pause_done;
        logic [WK_W-1:0] wake_left;
        logic            ready;
    } wake_t;

    wake_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (!s_q.pause_done) begin
            if (s_q.pause_cnt == PAUSE_LAST) s_d.pause_done = 1'b1;
            else                             s_d.pause_cnt  = s_q.pause_cnt + 1'b1;
        end
        if (restart)
            s_d.wake_left = WAKE_INIT;
        else if (served && (s_q.wake_left != '0))
            s_d.wake_left = s_q.wake_left - 1'b1;
        s_d.ready = s_d.pause_done && (s_d.wake_left == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pause_cnt  <= '0;
            s_q.pause_done <= 1'b0;
            s_q.wake_left  <= WAKE_INIT;
            s_q.ready      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pause_done = s_q.pause_done;
    assign wake_need  = (s_q.wake_left != '0);
    assign ready      = s_q.ready;

endmodule

// File: rtl/drs_cycle_fsm.sv
module drs_cycle_fsm
    import drs_pkg::*;
#(
    parameter int CAS_LEAD = 2,
    parameter int RAS_LOW  = 6,
    parameter int RAS_PRE  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic bus_gnt,
    output logic bus_req,
    output logic cas_act,
    output logic ras_act,
    output logic done
);
    localparam int PH_A   = (CAS_LEAD > RAS_LOW) ? CAS_LEAD : RAS_LOW;
    localparam int PH_MAX = (PH_A > RAS_PRE) ? PH_A : RAS_PRE;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] LEAD_LAST = PH_W'(CAS_LEAD - 1);
    localparam logic [PH_W-1:0] LOW_LAST  = PH_W'(RAS_LOW - 1);
    localparam logic [PH_W-1:0] PRE_LAST  = PH_W'(RAS_PRE - 1);

    typedef struct packed {
        cyc_state_e      st;
        logic [PH_W-1:0] cnt;
    } fsm_t;

    fsm_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        case (s_q.st)
            CYC_IDLE: if (want) s_d.st = CYC_REQ;
            CYC_REQ: begin
                if (bus_gnt) begin
                    s_d.st  = CYC_CAS;
                    s_d.cnt = '0;
                end
            end
            CYC_CAS: begin
                if (s_q.cnt == LEAD_LAST) begin
                    s_d.st  = CYC_RAS;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            CYC_RAS: begin
                if (s_q.cnt == LOW_LAST) begin
                    s_d.st  = CYC_PRE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            CYC_PRE: begin
                if (s_q.cnt == PRE_LAST) begin
                    s_d.st  = CYC_IDLE;
                    s_d.cnt = '0;
                    done    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                s_d.st  = CYC_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= CYC_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_req = (s_q.st != CYC_IDLE);
    assign cas_act = (s_q.st == CYC_CAS) || (s_q.st == CYC_RAS);
    assign ras_act = (s_q.st == CYC_RAS);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int PAUSE_CYC   = 20000,
    parameter int WAKE_CNT    = 8,
    parameter int REF_PERIOD  = 1560,
    parameter int MAX_BACKLOG = 4,
    parameter int CAS_LEAD    = 2,
    parameter int RAS_LOW     = 6,
    parameter int RAS_PRE     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    output logic bus_req,
    output logic row_stb_n,
    output logic col_stb_lo_n,
    output logic col_stb_hi_n,
    output logic wr_n,
    output logic out_en_n,
    output logic ready,
    output logic deadline_miss
);
    logic pause_done, wake_need, ref_need;
    logic want, done, cas_act, ras_act;
    logic served_wake, served_ref;

    assign want        = pause_done && (wake_need || ref_need);
    assign served_wake = done && wake_need;
    assign served_ref  = done && !wake_need;

    drs_wake #(
        .PAUSE_CYC (PAUSE_CYC),
        .WAKE_CNT  (WAKE_CNT)
    ) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .served     (served_wake),
        .restart    (deadline_miss),
        .pause_done (pause_done),
        .wake_need  (wake_need),
        .ready      (ready)
    );

    drs_interval #(
        .REF_PERIOD  (REF_PERIOD),
        .MAX_BACKLOG (MAX_BACKLOG)
    ) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ready),
        .served (served_ref),
        .need   (ref_need),
        .miss   (deadline_miss)
    );

    drs_cycle_fsm #(
        .CAS_LEAD (CAS_LEAD),
        .RAS_LOW  (RAS_LOW),
        .RAS_PRE  (RAS_PRE)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (want),
        .bus_gnt (bus_gnt),
        .bus_req (bus_req),
        .cas_act (cas_act),
        .ras_act (ras_act),
        .done    (done)
    );

    assign row_stb_n    = !ras_act;
    assign col_stb_lo_n = !cas_act;
    assign col_stb_hi_n = !cas_act;
    assign wr_n         = 1'b1;
    assign out_en_n     = 1'b1;

endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int PAUSE_CYC = 20000,
    parameter int RAS_LOW   = 6
) (
    input logic clk,
    input logic rst_n,
    input logic bus_gnt,
    input logic bus_req,
    input logic row_stb_n,
    input logic col_stb_lo_n,
    input logic col_stb_hi_n,
    input logic wr_n,
    input logic out_en_n,
    input logic ready,
    input logic deadline_miss
);
    localparam int SR_W = $clog2(PAUSE_CYC + 1);
    localparam int LR_W = $clog2(RAS_LOW + 2);
    localparam logic [SR_W-1:0] SR_SAT = SR_W'(PAUSE_CYC);
    localparam logic [LR_W-1:0] LR_SAT = LR_W'(RAS_LOW + 1);
    localparam logic [LR_W-1:0] LR_EXP = LR_W'(RAS_LOW);

    logic [SR_W-1:0] since_q;
    logic [LR_W-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q   <= '0;
            low_run_q <= '0;
        end else begin
            if (since_q != SR_SAT) since_q <= since_q + 1'b1;
            if (row_stb_n)               low_run_q <= '0;
            else if (low_run_q != LR_SAT) low_run_q <= low_run_q + 1'b1;
        end
    end

    p_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (since_q == SR_SAT));

    p_cas_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !row_stb_n |-> (!col_stb_lo_n && !col_stb_hi_n));

    p_cas_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_stb_n) |-> $past(!col_stb_lo_n && !col_stb_hi_n));

    p_ras_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_stb_n) |-> (low_run_q == LR_EXP));

    p_prechg_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_stb_n) |-> bus_req);

    p_bus_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n && out_en_n);

    p_grant_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_stb_lo_n) |-> $past(bus_gnt && bus_req));

    p_release_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (row_stb_n && col_stb_lo_n && col_stb_hi_n));

    p_ready_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $fell(bus_req));

    p_miss_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        deadline_miss |=> (!ready && !deadline_miss));

endmodule

bind dram_refresh_seq drs_checker #(
    .PAUSE_CYC (PAUSE_CYC),
    .RAS_LOW   (RAS_LOW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_gnt       (bus_gnt),
    .bus_req       (bus_req),
    .row_stb_n     (row_stb_n),
    .col_stb_lo_n  (col_stb_lo_n),
    .col_stb_hi_n  (col_stb_hi_n),
    .wr_n          (wr_n),
    .out_en_n      (out_en_n),
    .ready         (ready),
    .deadline_miss (deadline_miss)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P_PAUSE    = 40;
    localparam int P_WAKE     = 8;
    localparam int P_PERIOD   = 60;
    localparam int P_BACKLOG  = 3;
    localparam int P_LEAD     = 2;
    localparam int P_LOW      = 4;
    localparam int P_PRE      = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_gnt = 1'b0;
    logic bus_req, row_stb_n, col_stb_lo_n, col_stb_hi_n, wr_n, out_en_n, ready, deadline_miss;

    int n_checks = 0;
    int n_errors = 0;
    bit arb_en = 1'b0;
    int arb_max = 0;
    int ras_falls = 0;
    int epoch_falls = 0;
    int miss_count = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC (P_PAUSE), .WAKE_CNT (P_WAKE), .REF_PERIOD (P_PERIOD),
        .MAX_BACKLOG (P_BACKLOG), .CAS_LEAD (P_LEAD), .RAS_LOW (P_LOW), .RAS_PRE (P_PRE)
    ) uut (
        .clk (clk), .rst_n (rst_n), .bus_gnt (bus_gnt), .bus_req (bus_req),
        .row_stb_n (row_stb_n), .col_stb_lo_n (col_stb_lo_n), .col_stb_hi_n (col_stb_hi_n),
        .wr_n (wr_n), .out_en_n (out_en_n), .ready (ready), .deadline_miss (deadline_miss)
    );

    function automatic int exp_refreshes(input int cycles);
        return cycles / P_PERIOD;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Arbiter model: grants only on a live request, after a random delay.
    initial begin
        int gdelay;
        gdelay = -1;
        forever begin
            @(negedge clk);
            if (!rst_n || !bus_req) begin
                bus_gnt = 1'b0;
                gdelay  = -1;
            end else if (!bus_gnt && arb_en) begin
                if (gdelay < 0) gdelay = $urandom_range(arb_max, 0);
                if (gdelay == 0) bus_gnt = 1'b1;
                else gdelay--;
            end
        end
    end

    // Pin monitor: phase widths, strobe order and wake-burst length.
    initial begin
        bit prev_ras, prev_ready, in_pre;
        int lead_cnt, low_cnt, pre_cnt;
        prev_ras = 1'b1; prev_ready = 1'b0; in_pre = 1'b0;
        lead_cnt = 0; low_cnt = 0; pre_cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_ras = 1'b1; prev_ready = 1'b0; in_pre = 1'b0;
                lead_cnt = 0; low_cnt = 0; epoch_falls = 0;
            end else begin
                if (deadline_miss) begin
                    miss_count++;
                    epoch_falls = 0;
                end
                if (in_pre) begin
                    if (bus_req && row_stb_n && col_stb_lo_n) pre_cnt++;
                    else begin
                        check(pre_cnt == P_PRE, "R3 precharge width", pre_cnt, P_PRE);
                        in_pre = 1'b0;
                    end
                end
                if (row_stb_n && !col_stb_lo_n && !col_stb_hi_n) lead_cnt++;
                if (prev_ras && !row_stb_n) begin
                    check(lead_cnt == P_LEAD, "R2 column lead", lead_cnt, P_LEAD);
                    check(bus_gnt == 1'b1, "R5 grant before strobes", int'(bus_gnt), 1);
                    check(wr_n && out_en_n, "R4 data bus quiet", int'(wr_n && out_en_n), 1);
                    lead_cnt = 0;
                    ras_falls++;
                    if (!ready) epoch_falls++;
                end
                if (!row_stb_n) begin
                    low_cnt++;
                    if (col_stb_lo_n || col_stb_hi_n)
                        check(1'b0, "R2 column held", 1, 0);
                end
                if (!prev_ras && row_stb_n) begin
                    check(low_cnt == P_LOW, "R3 row low width", low_cnt, P_LOW);
                    low_cnt = 0;
                    in_pre  = 1'b1;
                    pre_cnt = bus_req ? 1 : 0;
                end
                if (!prev_ready && ready)
                    check(epoch_falls == P_WAKE, "R6 wake burst length", epoch_falls, P_WAKE);
                prev_ras   = row_stb_n;
                prev_ready = ready;
            end
        end
    end

    task automatic wait_ready(input int limit, input string req);
        int n;
        n = 0;
        while (!ready && n < limit) begin
            @(negedge clk);
            n++;
        end
        check(ready == 1'b1, req, int'(ready), 1);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        int seed, n, start, drops, misses0, falls0;
        seed = $urandom(32'd20241);
        // R1: reset state
        repeat (5) @(negedge clk);
        check(row_stb_n && col_stb_lo_n && col_stb_hi_n, "R1 strobes idle in reset",
              int'({row_stb_n, col_stb_lo_n, col_stb_hi_n}), 7);
        check(!bus_req && !ready && !deadline_miss, "R1 outputs low in reset",
              int'({bus_req, ready, deadline_miss}), 0);
        arb_en  = 1'b1;
        arb_max = 0;
        rst_n   = 1'b1;
        // R1: pause length before the first request
        n = 0;
        drops = 0;
        while (!bus_req && n < 10 * P_PAUSE) begin
            @(negedge clk);
            if (ready) drops++;
            if (!bus_req) n++;
        end
        check(n >= P_PAUSE && n <= P_PAUSE + 2, "R1 power-up pause", n, P_PAUSE);
        check(drops == 0, "R1 ready low during pause", drops, 0);
        // R6: wake burst then ready
        wait_ready(P_WAKE * 40, "R6 ready after wake burst");
        check(ras_falls == P_WAKE, "R6 cycles before ready", ras_falls, P_WAKE);

        // R7: steady refresh rate with immediate grants
        falls0 = ras_falls;
        repeat (20 * P_PERIOD) @(negedge clk);
        n = ras_falls - falls0;
        check(n >= exp_refreshes(20 * P_PERIOD) - 1 && n <= exp_refreshes(20 * P_PERIOD) + 1,
              "R7 refresh rate", n, exp_refreshes(20 * P_PERIOD));

        // R8: grant withheld for a window the backlog can absorb
        misses0 = miss_count;
        arb_en = 1'b0;
        repeat ((P_BACKLOG - 1) * P_PERIOD) @(negedge clk);
        arb_en = 1'b1;
        drops = 0;
        repeat (4 * P_PERIOD) begin
            @(negedge clk);
            if (!ready) drops++;
        end
        check(miss_count == misses0, "R8 backlog absorbed", miss_count - misses0, 0);
        check(drops == 0, "R8 ready held", drops, 0);

        // R10: random grant latency
        arb_max = P_PERIOD;
        drops = 0;
        falls0 = ras_falls;
        repeat (60 * P_PERIOD) begin
            @(negedge clk);
            if (!ready) drops++;
        end
        check(miss_count == misses0, "R10 no miss under random latency", miss_count - misses0, 0);
        check(drops == 0, "R10 ready never drops", drops, 0);
        n = ras_falls - falls0;
        check(n >= exp_refreshes(60 * P_PERIOD) - P_BACKLOG && n <= exp_refreshes(60 * P_PERIOD) + 1,
              "R10 refreshes kept up", n, exp_refreshes(60 * P_PERIOD));

        // R9: withhold grant until the backlog overflows
        arb_max = 0;
        arb_en = 1'b0;
        start = 0;
        while (!deadline_miss && start < (P_BACKLOG + 3) * P_PERIOD) begin
            @(negedge clk);
            start++;
        end
        check(deadline_miss == 1'b1, "R9 miss raised", int'(deadline_miss), 1);
        check(start >= (P_BACKLOG - 1) * P_PERIOD && start <= (P_BACKLOG + 2) * P_PERIOD,
              "R9 miss timing", start, P_BACKLOG * P_PERIOD);
        falls0 = ras_falls;
        @(negedge clk);
        check(ready == 1'b0, "R9 ready dropped", int'(ready), 0);
        check(deadline_miss == 1'b0, "R9 single-cycle pulse", int'(deadline_miss), 0);
        arb_en = 1'b1;
        wait_ready(P_WAKE * 40, "R9 ready restored");
        check(ras_falls - falls0 == P_WAKE, "R9 wake rerun count", ras_falls - falls0, P_WAKE);

        // R7: rate again after recovery
        falls0 = ras_falls;
        repeat (10 * P_PERIOD) @(negedge clk);
        n = ras_falls - falls0;
        check(n >= exp_refreshes(10 * P_PERIOD) - 1 && n <= exp_refreshes(10 * P_PERIOD) + 1,
              "R7 rate after recovery", n, exp_refreshes(10 * P_PERIOD));
        check(wr_n && out_en_n, "R4 enables high at end", int'(wr_n && out_en_n), 1);

        finished = 1'b1;
        summary();
    end

endmodule